// File: doc/BRIEF.md
# Single-Bus Datapath with Hardwired Step Sequencer

This block is a small processor core in which every register (program counter, memory address and data registers, instruction register, the Y operand latch, the Z result latch and four general registers) exchanges data over one shared internal bus. A two-input ALU takes one operand from the bus and the other from a multiplexer that picks either Y or the constant 4; its result is captured in Z. A step counter and a decode of the instruction opcode form hardwired logic: each gating signal is a sum of step-times ANDed with decoded opcodes.

Each instruction runs as a fixed list of bus transfer steps. Fetch takes the first three steps. Register-indirect ALU operations (add, subtract, exclusive-or of a memory word into a register) finish at step 7. An unconditional branch and a branch-if-negative finish at step 5, and a branch-if-negative that is not taken finishes at step 4. Steps that wait for memory hold the step counter until the memory raises its completion input. The step number, the end-of-instruction strobe and the bus value are brought out so the sequencing can be observed.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to step 1 with the program counter and all registers zero, and `mem_rd` low after that edge.
- R2: In step 1 the block issues a read at the program counter; `mem_rd` pulses for one cycle with `mem_addr` equal to that address, the memory word becomes the instruction, and the next fetch address is the previous one plus 4 unless a branch is taken.
- R3: In step 2, and in step 5 of an ALU instruction, the step counter holds until `mem_done` is high at a clock edge; at every edge where `mem_done` is high the data register captures `mem_rdata`.
- R4: While `run` is low at a clock edge, the step number, the program counter and every register hold, and no read is issued.
- R5: Opcode field IR[15:12] values 1, 4 and 5 select add, subtract and exclusive-or: the word at the address held in register IR[11:10] is read, the result is Rd op word (Rd is register IR[9:8], subtract gives Rd minus word) and is written to Rd; `instr_end` is high in step 7 with the result on `bus_mon`.
- R6: The negative flag takes the most significant bit of the result of each ALU instruction and is zero after reset; it changes at no other time.
- R7: Opcode 2 is an unconditional branch to the address after the branch plus the sign-extended offset IR[7:0]; `instr_end` is high in step 5 with the target on `bus_mon`, and the next fetch is at the target.
- R8: Opcode 3 branches as in R7 when the negative flag is 1; when it is 0, `instr_end` is high in step 4 with `bus_mon` zero and fetch continues sequentially.
- R9: Any other opcode ends in step 4 with `bus_mon` zero and changes no register.
- R10: At most one source drives the internal bus in any step and the bus reads zero when none does; after an edge where `instr_end` and `run` are high the step number is 1, and the step number stays between 1 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Step counter and register loads advance only while high |
| mem_rdata | input | DW | Memory read data |
| mem_done | input | 1 | Memory function completed |
| mem_addr | output | DW | Memory address, always the address register |
| mem_rd | output | 1 | One-cycle read request |
| step | output | 3 | Current control step, 1 to 7 |
| instr_end | output | 1 | Last step of the current instruction |
| bus_mon | output | DW | Value on the internal bus |

## Verification
The assertions take for granted that the memory raises `mem_done` only after a read request and keeps it high until an edge at which `run` is also high, so no completion is lost while the sequencer is frozen. The bench memory model answers each read after 0 to 3 cycles chosen from the address, holds its completion across any `run`-low window, and `run` is dropped for three cycles out of every forty-one regardless of the step in progress. A reference instruction model in the bench predicts every read address and every end-of-instruction step and bus value for a program looping through all opcodes, both branch directions and both flag values.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW   = 16,
  parameter int OFFW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [2:0]    step,
  output logic          instr_end,
  output logic [DW-1:0] bus_mon
);
  localparam logic [DW-1:0] FOUR = DW'(4);
  localparam logic [3:0] OP_ADD = 4'd1, OP_BR = 4'd2, OP_BRN = 4'd3,
                         OP_SUB = 4'd4, OP_XOR = 4'd5;

  logic [DW-1:0] pc, mar, mdr, ir, y, z, bus, alu_a, alu_y;
  logic [DW-1:0] rf [4];
  logic          neg, rd_q;

  wire [3:0] op  = ir[DW-1:DW-4];
  wire [1:0] src = ir[DW-5:DW-6];
  wire [1:0] dst = ir[DW-7:DW-8];
  wire [DW-1:0] offs = {{(DW-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};

  wire t1 = step == 3'd1, t2 = step == 3'd2, t3 = step == 3'd3, t4 = step == 3'd4;
  wire t5 = step == 3'd5, t6 = step == 3'd6, t7 = step == 3'd7;

  wire is_alu = op == OP_ADD || op == OP_SUB || op == OP_XOR;
  wire is_br  = op == OP_BR;
  wire is_brn = op == OP_BRN;
  wire take   = is_br || (is_brn && neg);

  wire pc_out   = t1;
  wire mdr_out  = t3 || (t6 && is_alu);
  wire z_out    = t2 || (t7 && is_alu) || (t5 && take);
  wire rsrc_out = t4 && is_alu;
  wire rdst_out = t5 && is_alu;
  wire off_out  = t4 && take;
  wire mar_in   = t1 || (t4 && is_alu);
  wire pc_in    = t2 || (t5 && take);
  wire y_in     = t2 || (t5 && is_alu);
  wire ir_in    = t3;
  wire z_in     = t1 || (t6 && is_alu) || (t4 && take);
  wire rdst_in  = t7 && is_alu;
  wire wmfc     = t2 || (t5 && is_alu);
  wire sel4     = t1;
  wire n_ld     = t6 && is_alu;
  wire fin      = (t7 && is_alu) || (t5 && take) || (t4 && !is_alu && !take);

  always_comb begin
    bus = '0;
    if (pc_out)        bus = pc;
    else if (mdr_out)  bus = mdr;
    else if (z_out)    bus = z;
    else if (rsrc_out) bus = rf[src];
    else if (rdst_out) bus = rf[dst];
    else if (off_out)  bus = offs;
  end

  assign alu_a = sel4 ? FOUR : y;

  always_comb begin
    alu_y = alu_a + bus;
    if (t6 && op == OP_SUB) alu_y = alu_a - bus;
    if (t6 && op == OP_XOR) alu_y = alu_a ^ bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; y <= '0; z <= '0;
      neg <= 1'b0; rd_q <= 1'b0; step <= 3'd1;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      rd_q <= run && mar_in;
      if (mem_done) mdr <= mem_rdata;
      if (run) begin
        if (pc_in)   pc <= bus;
        if (mar_in)  mar <= bus;
        if (ir_in)   ir <= bus;
        if (y_in)    y <= bus;
        if (z_in)    z <= alu_y;
        if (n_ld)    neg <= alu_y[DW-1];
        if (rdst_in) rf[dst] <= bus;
        if (fin)                    step <= 3'd1;
        else if (!wmfc || mem_done) step <= step + 3'd1;
      end
    end
  end

  assign mem_addr  = mar;
  assign mem_rd    = rd_q;
  assign instr_end = fin;
  assign bus_mon   = bus;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> step == 3'd1 && !mem_rd && pc == '0);
  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    run && t2 && mem_done |=> pc == mar + FOUR);
  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && wmfc && !mem_done |=> $stable(step));
  // R3
  mdr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    mem_done |=> mdr == $past(mem_rdata));
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(step) && $stable(pc) && $stable(ir) && !mem_rd);
  // R6
  flag_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(run && t6 && is_alu) |=> $stable(neg));
  // R10
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, mdr_out, z_out, rsrc_out, rdst_out, off_out}));
  // R10
  end_restart_chk: assert property (@(posedge clk) disable iff (rst)
    run && fin |=> step == 3'd1);
  // R10
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    step >= 3'd1 && step <= 3'd7);
endmodule

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, run = 1'b1, mem_done = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_addr, bus_mon;
  logic mem_rd, instr_end;
  logic [2:0] step;

  sbus_datapath uut (
    .clk(clk), .rst(rst), .run(run), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .step(step), .instr_end(instr_end),
    .bus_mon(bus_mon)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit mon_on = 1'b0;
  int q_kind[$];
  logic [15:0] q_val[$];
  int q_st[$];
  string q_tag[$];

  function automatic logic [15:0] memv(logic [15:0] a);
    if (a[15:10] != 6'd0) return a ^ 16'hA5C3;
    case (a[9:2])
      8'd0: return 16'h1100;  // add (R0),R1
      8'd1: return 16'h1600;  // add (R1),R2
      8'd2: return 16'h3004;  // branch if negative +4
      8'd4: return 16'h4B00;  // sub (R2),R3
      8'd5: return 16'h5700;  // xor (R1),R3
      8'd6: return 16'h3008;  // branch if negative +8
      8'd8: return 16'h20DC;  // branch -36
      8'd9: return 16'h20D8;  // branch -40
      default: return 16'h0000;
    endcase
  endfunction

  task automatic push(int k, logic [15:0] v, int st, string tag);
    q_kind.push_back(k); q_val.push_back(v); q_st.push_back(st); q_tag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic build(int n);
    logic [15:0] pc = '0, ir, a, d, res, tgt;
    logic [15:0] r [4];
    logic neg = 1'b0;
    for (int k = 0; k < 4; k++) r[k] = '0;
    for (int i = 0; i < n; i++) begin
      push(0, pc, 0, "R2");
      ir = memv(pc);
      pc = pc + 16'd4;
      if (ir[15:12] == 4'd1 || ir[15:12] == 4'd4 || ir[15:12] == 4'd5) begin
        a = r[ir[11:10]];
        push(0, a, 0, "R5");
        d = memv(a);
        if (ir[15:12] == 4'd1)      res = r[ir[9:8]] + d;
        else if (ir[15:12] == 4'd4) res = r[ir[9:8]] - d;
        else                        res = r[ir[9:8]] ^ d;
        r[ir[9:8]] = res;
        neg = res[15];
        push(1, res, 7, "R5");
      end else if (ir[15:12] == 4'd2 || (ir[15:12] == 4'd3 && neg)) begin
        tgt = pc + {{8{ir[7]}}, ir[7:0]};
        push(1, tgt, 5, ir[15:12] == 4'd2 ? "R7" : "R8 R6");
        pc = tgt;
      end else if (ir[15:12] == 4'd3) begin
        push(1, 16'h0, 4, "R8 R6");
      end else begin
        push(1, 16'h0, 4, "R9");
      end
    end
  endtask

  // memory model and run pattern, driven just after each rising edge
  initial begin
    int cnt = 0;
    bit pend = 1'b0;
    logic [15:0] la = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (mem_done && run) mem_done = 1'b0;
      if (mem_rd) begin
        pend = 1'b1; la = mem_addr; cnt = int'(mem_addr[3:2]);
      end
      if (pend) begin
        if (cnt == 0) begin
          mem_done = 1'b1; mem_rdata = memv(la); pend = 1'b0;
        end else cnt--;
      end
      run = (cyc % 41) < 38;
    end
  end

  // scoreboard monitor
  initial begin
    bit pv = 1'b0;
    logic [2:0] p_step = '0;
    logic p_run = 1'b0, p_done = 1'b0, p_end = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (pv && !p_run)
          check(step == p_step && !mem_rd, "R4", "step held while run low", int'(step), int'(p_step));
        if (pv && p_step == 3'd2 && !p_done && p_run)
          check(step == 3'd2, "R3", "wait step held", int'(step), 2);
        if (pv && p_end && p_run)
          check(step == 3'd1, "R10", "step after end", int'(step), 1);
        if (mem_rd && q_kind.size() > 0) begin
          check(q_kind[0] == 0, q_tag[0], "read where end expected", 0, q_kind[0]);
          check(mem_addr == q_val[0], q_tag[0], "read address", int'(mem_addr), int'(q_val[0]));
          void'(q_kind.pop_front()); void'(q_val.pop_front());
          void'(q_st.pop_front()); void'(q_tag.pop_front());
        end
        if (instr_end && run && q_kind.size() > 0) begin
          check(q_kind[0] == 1, q_tag[0], "end where read expected", 1, q_kind[0]);
          check(int'(step) == q_st[0], q_tag[0], "end step", int'(step), q_st[0]);
          check(bus_mon == q_val[0], q_tag[0], "end bus value", int'(bus_mon), int'(q_val[0]));
          void'(q_kind.pop_front()); void'(q_val.pop_front());
          void'(q_st.pop_front()); void'(q_tag.pop_front());
        end
        pv = 1'b1;
        p_step = step; p_run = run; p_done = mem_done; p_end = instr_end;
      end
    end
  end

  initial begin
    build(40);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(step == 3'd1, "R1", "reset step", int'(step), 1);
    check(!mem_rd, "R1", "reset read", int'(mem_rd), 0);
    check(mem_addr == 16'h0, "R1", "reset address", int'(mem_addr), 0);
    check(bus_mon == 16'h0, "R1", "reset bus (PC)", int'(bus_mon), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;
    while (q_kind.size() > 0 && cyc < 20000) @(negedge clk);
    if (q_kind.size() > 0)
      check(1'b0, q_tag[0], "watchdog expired with items pending", q_kind.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule